// File: doc/BRIEF.md
# Two-Level Interrupt Collector

This block gathers interrupt events from four sections of a host-attached link-layer device: link/PHY control, isochronous transmit, isochronous receive and asynchronous transfer. Each section owns a 20-bit status register whose bits latch on single-cycle event pulses. Each section also owns a 20-bit enable register, with one mask bit per status bit. A global summary register shows, one bit per section, whether that section holds any enabled status bit. The summary bits drive one active-low interrupt line to the host.

The host services an interrupt in three steps. It reads the summary to find the section, then reads that section's status register, then writes ones to the bits it has handled. The summary bit keeps no state of its own, so it drops as soon as the last enabled status bit of its section is cleared. The same flow works with the interrupt line ignored, for a host that polls. Register access goes through a plain port with address, write data, write strobe, read strobe and read data.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status and enable register reads zero and `irq_no` is high.
- R2: An event pulse on `evt_i` bit 20*s+b sets status bit b of section s. The bit stays set after the pulse ends. A status bit never becomes set without an event.
- R3: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R5: Status registers are at byte addresses 0x008 (section 0, link/PHY), 0x02C (section 1, transmit), 0x04C (section 2, receive) and 0x0A0 (section 3, asynchronous). Each section's enable register is at its status address plus 4. Status and enable registers are 20 bits wide, and read data bits 31:20 are zero.
- R6: The summary register at 0x018 reads bit s as the OR of section s's status bits that are enabled. Bits 31:4 read zero.
- R7: `irq_no` is low exactly when at least one summary bit is set. It follows the registered state in the same cycle, with no added delay.
- R8: The summary register ignores writes. Its bits fall on their own once the enabled status bits of that section are cleared.
- R9: A status bit whose enable is 0 still latches and reads back, but it does not affect the summary or `irq_no`.
- R10: `rdata_o` is zero when `re_i` is low. It is also zero on a read of an address that is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 80 | Event pulses; bits 20*s+19 to 20*s belong to section s |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational from `addr_i` while `re_i` is high |
| irq_no | output | 1 | Interrupt to the host, active low |

## Verification
The bench targets the cycle in which an event and a write-1 clear reach the same bit. A design that gives the clear priority loses that event, and the bit reads zero. It checks that writing zeros to a status register leaves it unchanged. A design that loads the write data instead of masking with it would wipe pending bits. It also writes to the summary address and checks that the summary still follows the section state. A design that stored the summary would keep the interrupt asserted after the acknowledge, or take on the written value. Bits that are set but disabled must not drive the line, and the enable registers must drop write data above bit 19.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSEC = 4;
  localparam int SW   = 20;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam logic [AW-1:0] SUM_OFS = 12'h018;
  localparam logic [AW-1:0] EN_GAP  = 12'h004;
  // section order fixes the summary bit position
  localparam logic [AW-1:0] STAT_OFS [NSEC] = '{12'h008, 12'h02C, 12'h04C, 12'h0A0};
endpackage

// File: rtl/irq_section.sv
module irq_section #(
  parameter int SW = 20,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] STAT_ADDR = '0,
  parameter logic [AW-1:0] EN_ADDR   = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [SW-1:0] stat_o,
  output logic [SW-1:0] en_o,
  output logic          pend_o
);
  logic [SW-1:0] stat_q, en_q, clr_mask;

  assign clr_mask = (we_i && addr_i == STAT_ADDR) ? wdata_i[SW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      // new events win over a same-cycle acknowledge
      stat_q <= (stat_q & ~clr_mask) | evt_i;
      if (we_i && addr_i == EN_ADDR) en_q <= wdata_i[SW-1:0];
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
  import irq_pkg::*;
(
  input  logic [AW-1:0]      addr_i,
  input  logic               re_i,
  input  logic [NSEC*SW-1:0] stat_i,
  input  logic [NSEC*SW-1:0] en_i,
  input  logic [NSEC-1:0]    sum_i,
  output logic [DW-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == SUM_OFS) rdata_o[NSEC-1:0] = sum_i;
      for (int s = 0; s < NSEC; s++) begin
        if (addr_i == STAT_OFS[s])          rdata_o[SW-1:0] = stat_i[s*SW +: SW];
        if (addr_i == STAT_OFS[s] + EN_GAP) rdata_o[SW-1:0] = en_i[s*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSEC*SW-1:0] evt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_no
);
  logic [NSEC*SW-1:0] stat_all, en_all;
  logic [NSEC-1:0]    sum;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    irq_section #(
      .SW(SW), .DW(DW), .AW(AW),
      .STAT_ADDR(STAT_OFS[s]),
      .EN_ADDR(STAT_OFS[s] + EN_GAP)
    ) u_sec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[s*SW +: SW]),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .we_i    (we_i),
      .stat_o  (stat_all[s*SW +: SW]),
      .en_o    (en_all[s*SW +: SW]),
      .pend_o  (sum[s])
    );
  end

  irq_rdmux u_rd (
    .addr_i  (addr_i),
    .re_i    (re_i),
    .stat_i  (stat_all),
    .en_i    (en_all),
    .sum_i   (sum),
    .rdata_o (rdata_o)
  );

  assign irq_no = ~|sum;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NSEC*SW-1:0] evt_i,
  input logic [AW-1:0]      addr_i,
  input logic               re_i,
  input logic [DW-1:0]      rdata_o,
  input logic               irq_no,
  input logic [NSEC*SW-1:0] stat_all,
  input logic [NSEC*SW-1:0] en_all
);
  logic [NSEC-1:0] sum_ref;
  always_comb
    for (int s = 0; s < NSEC; s++)
      sum_ref[s] = |(stat_all[s*SW +: SW] & en_all[s*SW +: SW]);

  a_r2_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_all & $past(evt_i)) == $past(evt_i)));

  a_r2_no_set_without_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(evt_i)) == '0));

  a_r7_irq_low_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (|(stat_all & en_all)));

  a_r7_irq_high_none_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no |-> ((stat_all & en_all) == '0));

  a_r6_summary_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == SUM_OFS) |-> (rdata_o == {{(DW-NSEC){1'b0}}, sum_ref}));

  a_r10_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> (rdata_o == '0));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i), .re_i(re_i),
  .rdata_o(rdata_o), .irq_no(irq_no), .stat_all(stat_all), .en_all(en_all)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  import irq_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NSEC*SW-1:0] evt_i = '0;
  logic [AW-1:0]      addr_i = '0;
  logic [DW-1:0]      wdata_i = '0;
  logic               we_i = 1'b0;
  logic               re_i = 1'b0;
  logic [DW-1:0]      rdata_o;
  logic               irq_no;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  irq_aggregator dut (.*);

  // entry: {section[1:0], enable, event, clear, expected status, expected irq_no}
  localparam int NV = 5;
  localparam logic [2+4*SW:0] VEC [NV] = '{
    {2'd0, 20'h00001, 20'h00003, 20'h00001, 20'h00002, 1'b1},
    {2'd1, 20'hF0000, 20'h80000, 20'h00000, 20'h80000, 1'b0},
    {2'd2, 20'hFFFFF, 20'h0AAAA, 20'h0000A, 20'h0AAA0, 1'b0},
    {2'd3, 20'h00010, 20'h00011, 20'h00010, 20'h00001, 1'b1},
    {2'd0, 20'h55555, 20'hFFFFF, 20'hAAAAA, 20'h55555, 1'b0}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    re_i = 1'b0;
  endtask

  task automatic pulse(input int s, input logic [SW-1:0] m);
    @(negedge clk_i);
    evt_i = '0; evt_i[s*SW +: SW] = m;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 irq_no", {31'b0, irq_no}, 32'd1);
    rst_ni = 1'b1;
    for (int s = 0; s < NSEC; s++) begin
      rd(STAT_OFS[s], d); chk("R1 status", d, 0);
      rd(STAT_OFS[s] + EN_GAP, d); chk("R1 enable", d, 0);
    end

    // table walk: R2 R3 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      int s = int'(VEC[i][2+4*SW -: 2]);
      logic [SW-1:0] en  = VEC[i][4*SW   -: SW];
      logic [SW-1:0] ev  = VEC[i][3*SW   -: SW];
      logic [SW-1:0] clr = VEC[i][2*SW   -: SW];
      logic [SW-1:0] es  = VEC[i][SW     -: SW];
      logic          ei  = VEC[i][0];
      wr(STAT_OFS[s] + EN_GAP, {12'hFFF, en});
      rd(STAT_OFS[s] + EN_GAP, d); chk("R5 enable readback", d, {12'h0, en});
      pulse(s, ev);
      wr(STAT_OFS[s], {12'h0, clr});
      rd(STAT_OFS[s], d); chk("R2/R3 status", d, {12'h0, es});
      chk("R7/R9 irq_no", {31'b0, irq_no}, {31'b0, ei});
      rd(SUM_OFS, d); chk("R6 summary", d, ei ? 32'h0 : (32'h1 << s));
      wr(STAT_OFS[s], 32'hFFFFFFFF);
      wr(STAT_OFS[s] + EN_GAP, 32'h0);
      rd(STAT_OFS[s], d); chk("R3 clear all", d, 0);
    end

    // R3 writing zeros leaves bits set
    pulse(1, 20'h00F00);
    wr(STAT_OFS[1], 32'h0);
    rd(STAT_OFS[1], d); chk("R3 zero write", d, 32'h00F00);

    // R4 event and clear on the same bit in the same cycle
    @(negedge clk_i);
    addr_i = STAT_OFS[1]; wdata_i = 32'h00F00; we_i = 1'b1; evt_i[1*SW +: SW] = 20'h00100;
    @(negedge clk_i);
    we_i = 1'b0; evt_i = '0;
    rd(STAT_OFS[1], d); chk("R4 event wins", d, 32'h00100);
    wr(STAT_OFS[1], 32'hFFFFF);

    // R6 two sections pending, R8 summary ignores writes and self-clears
    wr(STAT_OFS[1] + EN_GAP, 32'h1);
    wr(STAT_OFS[3] + EN_GAP, 32'h1);
    pulse(1, 20'h1);
    pulse(3, 20'h1);
    rd(SUM_OFS, d); chk("R6 multi summary", d, 32'hA);
    wr(SUM_OFS, 32'h0);
    rd(SUM_OFS, d); chk("R8 summary write ignored", d, 32'hA);
    chk("R7 irq asserted", {31'b0, irq_no}, 0);
    wr(STAT_OFS[1], 32'h1);
    rd(SUM_OFS, d); chk("R8 partial ack", d, 32'h8);
    wr(STAT_OFS[3], 32'h1);
    rd(SUM_OFS, d); chk("R8 summary self-clear", d, 0);
    chk("R7 irq released", {31'b0, irq_no}, 1);

    // R10 unmapped and idle reads
    rd(12'h100, d); chk("R10 unmapped read", d, 0);
    pulse(0, 20'h1);
    @(negedge clk_i); addr_i = STAT_OFS[0]; re_i = 1'b0;
    #1 chk("R10 idle read", rdata_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule